// File: doc/BRIEF.md
# Machine Status Word and I/O Privilege Guard

This block keeps the processor's four-bit machine status word together with the two-bit I/O privilege field of the flags register. For each instruction the decoder presents, it decides whether a coprocessor fault or an I/O privilege fault must be raised. Software can load the status word and clear the task-switched bit. A store strobe captures the status word into a readback register. Writes to the flags register update the privilege field.

The four status bits sit in readback bits 3:0 as {TS, EM, MP, PE}, with PE at bit 0. Bits 15:4 of the readback are always zero.

Every instruction is marked by a one-cycle valid strobe and carries three class flags: coprocessor escape, WAIT and I/O access. The verdict is registered. It appears as a one-cycle fault pulse with a five-bit code in the cycle after the strobe. Code 7 means coprocessor not available. Code 13 means general protection.

Top module: `msw_priv_guard`

## Requirements
- R1: Synchronous active-high reset clears all four status bits and the I/O privilege field, drives the fault pulse low and the code to 0, and clears the readback register.
- R2: A status-word load writes load-data bits 3:1 into TS, EM and MP. Load-data bits 15:4 are ignored, and readback bits 15:4 always read 0.
- R3: A load with data bit 0 set makes PE 1. After that, a load with bit 0 clear leaves PE at 1, and only reset returns it to 0.
- R4: The clear-task-switched strobe forces TS to 0 and leaves PE, MP and EM unchanged. When it coincides with a load, TS ends at 0.
- R5: An escape instruction raises code 7 when EM is 1.
- R6: An escape instruction with EM at 0 raises code 7 when TS is 1, and raises no fault when both are 0.
- R7: A WAIT instruction raises code 7 only when MP and TS are both 1.
- R8: A flags write stores data bits 13:12 as the I/O privilege level. While PE is 1, an I/O access raises code 13 when the current level is numerically greater than that field (0 is most trusted). It is permitted when the current level is equal or smaller.
- R9: While PE is 0, no I/O access raises a fault.
- R10: An instruction reports at most one fault. A coprocessor fault (code 7) takes priority over an I/O fault.
- R11: The fault pulse is high for exactly one cycle, in the cycle after a valid strobe whose instruction faults. With no valid strobe there is no pulse. The code is 0 whenever the pulse is low.
- R12: The readback register takes the status word on the store strobe, becoming visible the next cycle. It holds its value between store strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msw_load | input | 1 | Load the status word from msw_load_data |
| msw_load_data | input | 16 | Status word write data; bits 3:0 = {TS, EM, MP, PE} |
| msw_store | input | 1 | Capture the status word into the readback register |
| msw_rd_data | output | 16 | Readback register; bits 15:4 zero |
| clr_ts | input | 1 | Clear the task-switched bit |
| flags_we | input | 1 | Flags write strobe |
| flags_wdata | input | 16 | Flags write data; bits 13:12 = I/O privilege level |
| cur_priv | input | 2 | Current privilege level, 0 most trusted |
| insn_valid | input | 1 | An instruction is presented this cycle |
| insn_esc | input | 1 | Instruction is a coprocessor escape |
| insn_wait | input | 1 | Instruction is WAIT |
| insn_io | input | 1 | Instruction performs an I/O access |
| fault_pulse | output | 1 | One-cycle fault indication |
| fault_code | output | 5 | 7 = coprocessor not available, 13 = general protection, 0 = none |

## Verification
The status and privilege registers can only be seen through the readback register and through the faults they cause. A corrupted status bit therefore shows up in two places. It appears in the readback one cycle after the next store strobe. It also appears as a wrong or missing fault pulse one cycle after the next instruction that depends on that bit.

A bad privilege field shows only through I/O faults in protected mode. The bench therefore sweeps equal, lower and higher current levels against several field values. A PE bit that fails to stick would surface in the same way: as a missing code 13 after a load with bit 0 clear.

// File: rtl/msw_guard_pkg.sv
package msw_guard_pkg;

    localparam int DATA_W   = 16;
    localparam int MSW_W    = 4;
    localparam int PRIV_W   = 2;
    localparam int IOPL_LSB = 12;
    localparam int CODE_W   = 5;

    typedef struct packed {
        logic ts;
        logic em;
        logic mp;
        logic pe;
    } msw_t;

    typedef enum logic [CODE_W-1:0] {
        FC_NONE   = 5'd0,
        FC_NO_CPU = 5'd7,
        FC_GPROT  = 5'd13
    } fault_code_e;

    typedef struct packed {
        logic        hit;
        fault_code_e code;
    } verdict_t;

    // Larger number means less trusted.
    function automatic logic less_trusted(input logic [PRIV_W-1:0] cur,
                                          input logic [PRIV_W-1:0] limit);
        return cur > limit;
    endfunction

endpackage

// File: rtl/msw_state_reg.sv
module msw_state_reg
    import msw_guard_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [W-1:0]      load_data,
    input  logic              clr_ts,
    input  logic              flags_we,
    input  logic [W-1:0]      flags_wdata,
    output msw_t              msw,
    output logic [PRIV_W-1:0] iopl
);

    msw_t msw_q, msw_d;
    logic [PRIV_W-1:0] iopl_q;

    always_comb begin
        msw_d = msw_q;
        if (load) begin
            msw_d.pe = msw_q.pe | load_data[0];
            msw_d.mp = load_data[1];
            msw_d.em = load_data[2];
            msw_d.ts = load_data[3];
        end
        if (clr_ts) msw_d.ts = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msw_q  <= '0;
            iopl_q <= '0;
        end else begin
            msw_q <= msw_d;
            if (flags_we) iopl_q <= flags_wdata[IOPL_LSB +: PRIV_W];
        end
    end

    assign msw  = msw_q;
    assign iopl = iopl_q;

endmodule

// File: rtl/fault_judge.sv
module fault_judge
    import msw_guard_pkg::*;
(
    input  msw_t              msw,
    input  logic [PRIV_W-1:0] iopl,
    input  logic [PRIV_W-1:0] cur_priv,
    input  logic              esc,
    input  logic              wt,
    input  logic              io,
    output verdict_t          verdict
);

    logic cop_fault, io_fault;

    always_comb begin
        cop_fault = (esc && (msw.em || msw.ts)) || (wt && msw.mp && msw.ts);
        io_fault  = io && msw.pe && less_trusted(cur_priv, iopl);
        if (cop_fault)     verdict = '{hit: 1'b1, code: FC_NO_CPU};
        else if (io_fault) verdict = '{hit: 1'b1, code: FC_GPROT};
        else               verdict = '{hit: 1'b0, code: FC_NONE};
    end

endmodule

// File: rtl/fault_pulse_reg.sv
module fault_pulse_reg
    import msw_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  verdict_t          verdict,
    output logic              pulse,
    output logic [CODE_W-1:0] code
);

    verdict_t q;

    always_ff @(posedge clk) begin
        if (rst)        q <= '{hit: 1'b0, code: FC_NONE};
        else if (valid) q <= verdict;
        else            q <= '{hit: 1'b0, code: FC_NONE};
    end

    assign pulse = q.hit;
    assign code  = q.code;

endmodule

// File: rtl/msw_priv_guard.sv
module msw_priv_guard
    import msw_guard_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               msw_load,
    input  logic [DATA_W-1:0]  msw_load_data,
    input  logic               msw_store,
    output logic [DATA_W-1:0]  msw_rd_data,
    input  logic               clr_ts,
    input  logic               flags_we,
    input  logic [DATA_W-1:0]  flags_wdata,
    input  logic [PRIV_W-1:0]  cur_priv,
    input  logic               insn_valid,
    input  logic               insn_esc,
    input  logic               insn_wait,
    input  logic               insn_io,
    output logic               fault_pulse,
    output logic [CODE_W-1:0]  fault_code
);

    msw_t              status_word;
    logic [PRIV_W-1:0] iopl;
    verdict_t          verdict;
    logic [MSW_W-1:0]  rd_q;

    msw_state_reg #(.W(DATA_W)) u_state (
        .clk         (clk),
        .rst         (rst),
        .load        (msw_load),
        .load_data   (msw_load_data),
        .clr_ts      (clr_ts),
        .flags_we    (flags_we),
        .flags_wdata (flags_wdata),
        .msw         (status_word),
        .iopl        (iopl)
    );

    fault_judge u_judge (
        .msw      (status_word),
        .iopl     (iopl),
        .cur_priv (cur_priv),
        .esc      (insn_esc),
        .wt       (insn_wait),
        .io       (insn_io),
        .verdict  (verdict)
    );

    fault_pulse_reg u_pulse (
        .clk     (clk),
        .rst     (rst),
        .valid   (insn_valid),
        .verdict (verdict),
        .pulse   (fault_pulse),
        .code    (fault_code)
    );

    always_ff @(posedge clk) begin
        if (rst)            rd_q <= '0;
        else if (msw_store) rd_q <= status_word;
    end

    assign msw_rd_data = {{(DATA_W-MSW_W){1'b0}}, rd_q};

endmodule

// File: rtl/msw_priv_guard_chk.sv
module msw_priv_guard_chk
    import msw_guard_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input msw_t              status_word,
    input logic              clr_ts,
    input logic              insn_valid,
    input logic              insn_esc,
    input logic              insn_io,
    input logic              fault_pulse,
    input logic [CODE_W-1:0] fault_code
);

    a_r3_pe_sticky: assert property (@(posedge clk) disable iff (rst)
        status_word.pe |=> status_word.pe);

    a_r4_clear_ts: assert property (@(posedge clk) disable iff (rst)
        clr_ts |=> !status_word.ts);

    a_r5_em_escape: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && insn_esc && status_word.em) |=> (fault_pulse && fault_code == 5'd7));

    a_r9_real_mode_io: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && !status_word.pe) |=> (fault_code != 5'd13));

    a_r11_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (!insn_valid) |=> !fault_pulse);

    a_r11_idle_code: assert property (@(posedge clk) disable iff (rst)
        !fault_pulse |-> (fault_code == 5'd0));

    a_r10_io_yields: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && insn_esc && insn_io && status_word.em) |=> (fault_code == 5'd7));

endmodule

bind msw_priv_guard msw_priv_guard_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .status_word (status_word),
    .clr_ts      (clr_ts),
    .insn_valid  (insn_valid),
    .insn_esc    (insn_esc),
    .insn_io     (insn_io),
    .fault_pulse (fault_pulse),
    .fault_code  (fault_code)
);

// File: tb/msw_priv_guard_test.sv
module msw_priv_guard_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        msw_load = 1'b0;
    logic [15:0] msw_load_data = '0;
    logic        msw_store = 1'b0;
    logic [15:0] msw_rd_data;
    logic        clr_ts = 1'b0;
    logic        flags_we = 1'b0;
    logic [15:0] flags_wdata = '0;
    logic [1:0]  cur_priv = '0;
    logic        insn_valid = 1'b0;
    logic        insn_esc = 1'b0;
    logic        insn_wait = 1'b0;
    logic        insn_io = 1'b0;
    logic        fault_pulse;
    logic [4:0]  fault_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    msw_priv_guard uut (
        .clk(clk), .rst(rst),
        .msw_load(msw_load), .msw_load_data(msw_load_data),
        .msw_store(msw_store), .msw_rd_data(msw_rd_data),
        .clr_ts(clr_ts), .flags_we(flags_we), .flags_wdata(flags_wdata),
        .cur_priv(cur_priv), .insn_valid(insn_valid),
        .insn_esc(insn_esc), .insn_wait(insn_wait), .insn_io(insn_io),
        .fault_pulse(fault_pulse), .fault_code(fault_code)
    );

    // Vector: [31:28] status nibble {TS,EM,MP,PE} loaded, [27:26] iopl,
    // [25:24] current level, [23] esc, [22] wait, [21] io,
    // [20] expected pulse, [19:15] expected code.
    localparam int NV = 16;
    localparam logic [31:0] VEC [NV] = '{
        {4'b0000, 2'd0, 2'd3, 3'b001, 1'b0, 5'd0,  15'd0}, // R9 real mode io
        {4'b0100, 2'd0, 2'd0, 3'b100, 1'b1, 5'd7,  15'd0}, // R5
        {4'b1000, 2'd0, 2'd0, 3'b100, 1'b1, 5'd7,  15'd0}, // R6
        {4'b0000, 2'd0, 2'd0, 3'b100, 1'b0, 5'd0,  15'd0}, // R6 none
        {4'b1000, 2'd0, 2'd0, 3'b010, 1'b0, 5'd0,  15'd0}, // R7 mp=0
        {4'b1010, 2'd0, 2'd0, 3'b010, 1'b1, 5'd7,  15'd0}, // R7
        {4'b0010, 2'd0, 2'd0, 3'b010, 1'b0, 5'd0,  15'd0}, // R7 ts=0
        {4'b0100, 2'd0, 2'd3, 3'b101, 1'b1, 5'd7,  15'd0}, // R10 real mode
        {4'b0001, 2'd1, 2'd2, 3'b001, 1'b1, 5'd13, 15'd0}, // R8
        {4'b0001, 2'd1, 2'd1, 3'b001, 1'b0, 5'd0,  15'd0}, // R8 equal
        {4'b0001, 2'd3, 2'd3, 3'b001, 1'b0, 5'd0,  15'd0}, // R8 equal low
        {4'b0001, 2'd0, 2'd1, 3'b001, 1'b1, 5'd13, 15'd0}, // R8
        {4'b0100, 2'd0, 2'd3, 3'b001, 1'b1, 5'd13, 15'd0}, // R3 pe stays
        {4'b0100, 2'd0, 2'd3, 3'b101, 1'b1, 5'd7,  15'd0}, // R10
        {4'b1110, 2'd0, 2'd3, 3'b011, 1'b1, 5'd7,  15'd0}, // R10 wait+io
        {4'b0000, 2'd2, 2'd1, 3'b001, 1'b0, 5'd0,  15'd0}  // R8 more trusted
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic load_msw(input logic [15:0] d, input logic clr);
        @(negedge clk); msw_load = 1'b1; msw_load_data = d; clr_ts = clr;
        @(negedge clk); msw_load = 1'b0; clr_ts = 1'b0;
    endtask

    task automatic store_rd();
        @(negedge clk); msw_store = 1'b1;
        @(negedge clk); msw_store = 1'b0;
    endtask

    task automatic run_vec(input int i);
        logic [31:0] v;
        v = VEC[i];
        @(negedge clk);
        msw_load = 1'b1; msw_load_data = {12'h0, v[31:28]};
        flags_we = 1'b1; flags_wdata = {2'b00, v[27:26], 12'h0};
        @(negedge clk);
        msw_load = 1'b0; flags_we = 1'b0;
        cur_priv = v[25:24];
        insn_valid = 1'b1; insn_esc = v[23]; insn_wait = v[22]; insn_io = v[21];
        @(negedge clk);
        insn_valid = 1'b0; insn_esc = 1'b0; insn_wait = 1'b0; insn_io = 1'b0;
        check($sformatf("vector %0d (R5/R6/R7/R8/R9/R10) pulse", i), 32'(fault_pulse), 32'(v[20]));
        check($sformatf("vector %0d (R5/R6/R7/R8/R9/R10) code", i), 32'(fault_code), 32'(v[19:15]));
    endtask

    initial begin
        do_reset();
        // R1
        @(negedge clk);
        check("R1 pulse after reset", 32'(fault_pulse), 0);
        check("R1 code after reset", 32'(fault_code), 0);
        check("R1 readback after reset", 32'(msw_rd_data), 0);
        store_rd();
        check("R1 status after reset", 32'(msw_rd_data), 0);

        // R2, R12
        load_msw(16'hFFFE, 1'b0);
        check("R12 readback holds before store", 32'(msw_rd_data), 0);
        store_rd();
        check("R2 load upper ignored", 32'(msw_rd_data), 32'h000E);

        // R4
        load_msw(16'h000E, 1'b1);
        store_rd();
        check("R4 clear with load", 32'(msw_rd_data), 32'h0006);
        load_msw(16'h000E, 1'b0);
        @(negedge clk); clr_ts = 1'b1;
        @(negedge clk); clr_ts = 1'b0;
        store_rd();
        check("R4 clear keeps others", 32'(msw_rd_data), 32'h0006);

        // R3
        load_msw(16'h0001, 1'b0);
        load_msw(16'h0000, 1'b0);
        store_rd();
        check("R3 pe sticky", 32'(msw_rd_data), 32'h0001);
        do_reset();
        store_rd();
        check("R3 reset clears pe", 32'(msw_rd_data), 0);

        // R11
        load_msw(16'h0004, 1'b0);
        @(negedge clk); insn_esc = 1'b1;
        @(negedge clk);
        check("R11 no pulse without valid", 32'(fault_pulse), 0);
        insn_valid = 1'b1;
        @(negedge clk); insn_valid = 1'b0; insn_esc = 1'b0;
        check("R11 pulse after valid", 32'(fault_pulse), 1);
        @(negedge clk);
        check("R11 pulse one cycle", 32'(fault_pulse), 0);
        check("R11 code idle", 32'(fault_code), 0);

        // Table walk from reset
        do_reset();
        for (int i = 0; i < NV; i++) run_vec(i);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule